// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Scheduler

This block owns the SDRAM command pins from power-up until the memory is usable, and afterwards takes them back whenever refresh work is due. After reset it holds the bus in NOP for a programmable stable-clock wait. It then closes all banks, issues a run of auto refreshes, and writes the mode register and the extended mode register. Only after that second register write has settled does it raise a ready flag to the front-end arbiter.

In normal operation an interval counter measures the time since the last auto refresh. When the interval runs out, it raises a refresh request. The arbiter answers with a grant once its own traffic is parked. If no grant arrives within a short slack window, the scheduler takes the bus anyway. Every refresh starts with a precharge of all banks, because the scheduler does not track which rows the arbiter left open.

A self-refresh request from the system takes precedence over everything else. It triggers a precharge and a long burst of auto refreshes, and then the self-refresh entry command with clock enable low. When the request is withdrawn, the block raises clock enable and keeps the bus in NOP for the refresh recovery time. It then repeats the refresh burst before handing the bus back. The mode word and the extended mode word (partial-array select in the low three bits, drive strength above them) are inputs.

Top module: `sdr_refresh_sched`

## Requirements
- R1: While reset is held, and afterwards for at least PWR_CYC clocks, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with cke high, and ready_o and rf_req_o are low.
- R2: Init order: precharge-all, then INIT_REF auto refreshes, then mode register write, then extended mode register write. The first refresh follows the precharge by T_RP clocks. Each later refresh, and the mode write, follows the previous refresh by T_RFC clocks. The extended write follows the mode write by T_MRD clocks. Pin codes {cs_n,ras_n,cas_n,we_n}: precharge 0010, auto refresh 0001, register write 0000.
- R3: The mode write drives mode_i on addr_o with ba_o=00. The extended write drives ext_mode_i on addr_o with ba_o=10. In ext_mode_i[2:0], 000 keeps all four banks under self refresh and 001 keeps only the banks with ba[1]=0.
- R4: ready_o rises exactly T_MRD clocks after the extended mode write. It is low whenever the scheduler is issuing commands, and it is low while a refresh or self-refresh sequence is under way.
- R5: While the block is idle, rf_req_o rises exactly REF_INT clocks after the most recent auto refresh.
- R6: A grant seen while rf_req_o is high produces the precharge on the next clock. A grant while rf_req_o is low has no effect: no command is issued and ready_o stays high.
- R7: With no grant, the precharge is issued SLACK clocks after rf_req_o rose.
- R8: Every refresh is a precharge-all (addr_o[10]=1), then one auto refresh T_RP clocks later. ready_o returns T_RFC clocks after the auto refresh.
- R9: Self-refresh entry: precharge-all, then SR_BURST auto refreshes spaced as in R2. T_RFC clocks after the last of them comes the entry command (code 0001 with cke low). After that, cke stays low with NOP while sr_req_i is high.
- R10: When sr_req_i falls, cke rises on the next clock with NOP. Only NOPs follow for T_RFC clocks, then SR_BURST auto refreshes. ready_o returns T_RFC clocks after the last one.
- R11: If sr_req_i and a refresh grant arrive in the same idle clock, the self-refresh sequence starts (precharge on the next clock) and rf_req_o drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | ADDR_W | Mode register value |
| ext_mode_i | input | ADDR_W | Extended mode register value (array select, drive strength) |
| sr_req_i | input | 1 | Level request to stay in self refresh |
| rf_gnt_i | input | 1 | Arbiter grant for a pending refresh |
| rf_req_o | output | 1 | Refresh due, asking the arbiter for the bus |
| ready_o | output | 1 | Bus available to the arbiter |
| cke_o | output | 1 | Clock enable pin |
| cs_n_o | output | 1 | Chip select pin |
| ras_n_o | output | 1 | Row strobe pin |
| cas_n_o | output | 1 | Column strobe pin |
| we_n_o | output | 1 | Write enable pin |
| ba_o | output | BA_W | Bank address pins |
| addr_o | output | ADDR_W | Address pins |

## Verification
Two events can land in the same idle clock: a matured refresh request being granted, and a self-refresh request rising. The bench waits for rf_req_o to rise, then drives sr_req_i and rf_gnt_i together in that same cycle. It judges the result by the command stream: the next precharge must be followed by a full burst of SR_BURST refreshes and the entry command, not by a single refresh and a return to idle, and rf_req_o must drop at once. A separate sweep moves the grant across every slot of the slack window and one slot past it, so the granted and forced starts meet at the window's edge.

// File: rtl/sdr_rfsh_pkg.sv
package sdr_rfsh_pkg;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PRE, ST_AR, ST_MRS, ST_EMRS, ST_IDLE, ST_SRE, ST_SRH, ST_SRX
  } st_e;

  typedef enum logic [2:0] {
    LC_PWR, LC_PRE, LC_AR, LC_MRS, LC_EMRS, LC_SRX
  } last_e;

  typedef enum logic [1:0] {
    PH_INIT, PH_REF, PH_SRIN, PH_SROUT
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP = 4'b0111;
  localparam pins_t PINS_PRE = 4'b0010;
  localparam pins_t PINS_REF = 4'b0001;
  localparam pins_t PINS_MRS = 4'b0000;

endpackage

// File: rtl/sdr_rfsh_delay.sv
module sdr_rfsh_delay #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  localparam logic [W-1:0] RV = W'(RST_VAL);

  logic [W-1:0] cnt_q, cnt_d;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    if (load_i)       cnt_d = load_val_i;
    else if (!zero_o) cnt_d = cnt_q - 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RV;
    else        cnt_q <= cnt_d;
  end

  // a new spacing may only start once the previous one has elapsed
  assert_load_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> zero_o);

endmodule

// File: rtl/sdr_rfsh_ivl.sv
module sdr_rfsh_ivl #(
  parameter int REF_INT = 64,
  parameter int SLACK   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ar_i,
  input  logic idle_i,
  output logic pend_o,
  output logic req_o,
  output logic expire_o
);
  localparam int IW = $clog2(REF_INT);
  localparam int SW = (SLACK > 1) ? $clog2(SLACK) : 1;
  localparam logic [IW-1:0] IV_TOP = IW'(REF_INT - 1);
  localparam logic [IW-1:0] IV_HIT = IW'(REF_INT - 2);
  localparam logic [SW-1:0] SL_TOP = SW'(SLACK - 1);

  logic [IW-1:0] ivl_q, ivl_d;
  logic          pend_q, pend_d;
  logic [SW-1:0] slk_q, slk_d;

  assign req_o    = pend_q && idle_i;
  assign expire_o = req_o && (slk_q == SL_TOP);
  assign pend_o   = pend_q;

  always_comb begin
    if (ar_i)                 ivl_d = '0;
    else if (ivl_q != IV_TOP) ivl_d = ivl_q + 1'b1;
    else                      ivl_d = ivl_q;

    if (ar_i)                 pend_d = 1'b0;
    else if (ivl_q == IV_HIT) pend_d = 1'b1;
    else                      pend_d = pend_q;

    if (!req_o)               slk_d = '0;
    else if (slk_q != SL_TOP) slk_d = slk_q + 1'b1;
    else                      slk_d = slk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      pend_q <= 1'b0;
      slk_q  <= '0;
    end else begin
      ivl_q  <= ivl_d;
      pend_q <= pend_d;
      slk_q  <= slk_d;
    end
  end

  assert_pend_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ar_i |=> !pend_q);

  assert_slack_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |=> (slk_q == '0));

endmodule

// File: rtl/sdr_rfsh_fsm.sv
module sdr_rfsh_fsm
  import sdr_rfsh_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              BA_W     = 2,
  parameter int              AP_BIT   = 10,
  parameter int              T_RP     = 3,
  parameter int              T_RFC    = 10,
  parameter int              T_MRD    = 2,
  parameter int              INIT_REF = 2,
  parameter int              SR_BURST = 4096,
  parameter int              DLY_W    = 16,
  parameter logic [BA_W-1:0] EMRS_BA  = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_req_i,
  input  logic              gnt_i,
  input  logic              pend_i,
  input  logic              expire_i,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] ext_mode_i,
  input  logic              dly_zero_i,
  output logic              dly_load_o,
  output logic [DLY_W-1:0]  dly_val_o,
  output logic              idle_o,
  output logic              ar_o,
  output pins_t             pins_o,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o
);
  localparam int LMAX = (SR_BURST > INIT_REF) ? SR_BURST : INIT_REF;
  localparam int LW   = $clog2(LMAX + 1);
  localparam logic [DLY_W-1:0] G_RP  = DLY_W'(T_RP - 2);
  localparam logic [DLY_W-1:0] G_RFC = DLY_W'(T_RFC - 2);
  localparam logic [DLY_W-1:0] G_MRD = DLY_W'(T_MRD - 2);

  st_e             state_q, state_d;
  last_e           last_q, last_d;
  phase_e          phase_q, phase_d;
  logic [LW-1:0]   left_q, left_d;
  pins_t           pins_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0] ba_d;
  logic            cke_d, ready_d;

  assign idle_o = (state_q == ST_IDLE);
  assign ar_o   = (state_q == ST_AR);

  // next-state sequencing
  always_comb begin
    state_d    = state_q;
    last_d     = last_q;
    phase_d    = phase_q;
    left_d     = left_q;
    dly_load_o = 1'b0;
    dly_val_o  = '0;
    case (state_q)
      ST_WAIT: begin
        if (dly_zero_i) begin
          case (last_q)
            LC_PWR:  state_d = ST_PRE;
            LC_PRE:  state_d = ST_AR;
            LC_AR: begin
              if (left_q != '0)            state_d = ST_AR;
              else if (phase_q == PH_INIT) state_d = ST_MRS;
              else if (phase_q == PH_SRIN) state_d = ST_SRE;
              else                         state_d = ST_IDLE;
            end
            LC_MRS:  state_d = ST_EMRS;
            LC_EMRS: state_d = ST_IDLE;
            LC_SRX:  state_d = ST_AR;
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_PRE: begin
        last_d = LC_PRE; dly_load_o = 1'b1; dly_val_o = G_RP; state_d = ST_WAIT;
      end
      ST_AR: begin
        last_d = LC_AR; left_d = left_q - 1'b1;
        dly_load_o = 1'b1; dly_val_o = G_RFC; state_d = ST_WAIT;
      end
      ST_MRS: begin
        last_d = LC_MRS; dly_load_o = 1'b1; dly_val_o = G_MRD; state_d = ST_WAIT;
      end
      ST_EMRS: begin
        last_d = LC_EMRS; dly_load_o = 1'b1; dly_val_o = G_MRD; state_d = ST_WAIT;
      end
      ST_IDLE: begin
        if (sr_req_i) begin
          state_d = ST_PRE; phase_d = PH_SRIN; left_d = LW'(SR_BURST);
        end else if (pend_i && (gnt_i || expire_i)) begin
          state_d = ST_PRE; phase_d = PH_REF; left_d = LW'(1);
        end
      end
      ST_SRE: state_d = ST_SRH;
      ST_SRH: if (!sr_req_i) state_d = ST_SRX;
      ST_SRX: begin
        last_d = LC_SRX; phase_d = PH_SROUT; left_d = LW'(SR_BURST);
        dly_load_o = 1'b1; dly_val_o = G_RFC; state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin values for the state being entered
  always_comb begin
    pins_d = PINS_NOP;
    addr_d = '0;
    ba_d   = '0;
    case (state_d)
      ST_PRE: begin
        pins_d = PINS_PRE;
        addr_d[AP_BIT] = 1'b1;
      end
      ST_AR, ST_SRE: pins_d = PINS_REF;
      ST_MRS: begin
        pins_d = PINS_MRS;
        addr_d = mode_i;
      end
      ST_EMRS: begin
        pins_d = PINS_MRS;
        addr_d = ext_mode_i;
        ba_d   = EMRS_BA;
      end
      default: pins_d = PINS_NOP;
    endcase
    cke_d   = !((state_d == ST_SRE) || (state_d == ST_SRH));
    ready_d = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      last_q  <= LC_PWR;
      phase_q <= PH_INIT;
      left_q  <= LW'(INIT_REF);
      pins_o  <= PINS_NOP;
      addr_o  <= '0;
      ba_o    <= '0;
      cke_o   <= 1'b1;
      ready_o <= 1'b0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
      phase_q <= phase_d;
      left_q  <= left_d;
      pins_o  <= pins_d;
      addr_o  <= addr_d;
      ba_o    <= ba_d;
      cke_o   <= cke_d;
      ready_o <= ready_d;
    end
  end

  assert_ready_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (pins_o == PINS_NOP) && cke_o);

  assert_cke_low_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> !ready_o);

  assert_exit_with_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (pins_o == PINS_NOP));

  assert_selfref_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && sr_req_i) |=> (phase_q == PH_SRIN) && (pins_o == PINS_PRE));

  assert_grant_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && pend_i && gnt_i && !sr_req_i) |=> (pins_o == PINS_PRE) && !ready_o);

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
  import sdr_rfsh_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int PWR_CYC  = 20000,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int T_MRD    = 2,
  parameter int INIT_REF = 2,
  parameter int REF_INT  = 1560,
  parameter int SLACK    = 8,
  parameter int SR_BURST = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] ext_mode_i,
  input  logic              sr_req_i,
  input  logic              rf_gnt_i,
  output logic              rf_req_o,
  output logic              ready_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int AP_BIT = 10;
  localparam int M1     = (PWR_CYC > T_RFC) ? PWR_CYC : T_RFC;
  localparam int M2     = (M1 > T_RP) ? M1 : T_RP;
  localparam int MAXD   = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int DLY_W  = $clog2(MAXD + 1);

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic             dly_load, dly_zero, idle, ar, pend, expire;
  logic [DLY_W-1:0] dly_val;
  pins_t            pins;

  sdr_rfsh_delay #(.W(DLY_W), .RST_VAL(PWR_CYC - 1)) u_delay (
    .clk(clk), .rst_n(rst_s_n), .load_i(dly_load), .load_val_i(dly_val), .zero_o(dly_zero)
  );

  sdr_rfsh_ivl #(.REF_INT(REF_INT), .SLACK(SLACK)) u_ivl (
    .clk(clk), .rst_n(rst_s_n), .ar_i(ar), .idle_i(idle),
    .pend_o(pend), .req_o(rf_req_o), .expire_o(expire)
  );

  sdr_rfsh_fsm #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .INIT_REF(INIT_REF), .SR_BURST(SR_BURST), .DLY_W(DLY_W),
    .EMRS_BA(BA_W'(2))
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .sr_req_i(sr_req_i), .gnt_i(rf_gnt_i),
    .pend_i(pend), .expire_i(expire), .mode_i(mode_i), .ext_mode_i(ext_mode_i),
    .dly_zero_i(dly_zero), .dly_load_o(dly_load), .dly_val_o(dly_val),
    .idle_o(idle), .ar_o(ar), .pins_o(pins), .cke_o(cke_o),
    .addr_o(addr_o), .ba_o(ba_o), .ready_o(ready_o)
  );

  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;

  assert_precharge_all_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pins == PINS_PRE) |-> addr_o[AP_BIT]);

  assert_req_only_ready_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    rf_req_o |-> ready_o);

endmodule

// File: tb/test_sdr_refresh_sched.sv
module test_sdr_refresh_sched;
  localparam int ADDR_W = 12, BA_W = 2, PWR_CYC = 20, T_RP = 3, T_RFC = 5, T_MRD = 2;
  localparam int INIT_REF = 2, REF_INT = 40, SLACK = 6, SR_BURST = 4;

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0, gnt = 1'b0;
  logic [ADDR_W-1:0] mode = '0, ext = '0, addr;
  logic [BA_W-1:0] ba;
  logic rf_req, ready, cke, cs_n, ras_n, cas_n, we_n;
  logic [3:0] code;
  int cyc = 0, checks = 0, fails = 0;

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign code = {cs_n, ras_n, cas_n, we_n};

  sdr_refresh_sched #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .PWR_CYC(PWR_CYC), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .INIT_REF(INIT_REF), .REF_INT(REF_INT), .SLACK(SLACK), .SR_BURST(SR_BURST)
  ) i_sdr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ext_mode_i(ext), .sr_req_i(sr_req),
    .rf_gnt_i(gnt), .rf_req_o(rf_req), .ready_o(ready), .cke_o(cke), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_cmd(output int t);
    do @(negedge clk); while (code == C_NOP);
    t = cyc;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t, tp, ta, tm, te, r, prev, last_ar, n, j, h, hx, ex;
    last_ar = 0;
    // init sweep over several mode / extended mode words
    for (int i = 0; i < 4; i++) begin
      mode = 12'h020 + 12'(i);
      ext  = 12'(i) | ((i % 2 == 1) ? 12'h020 : 12'h000);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(code == C_NOP && cke && !ready && !rf_req, "R1 reset pins", int'(code), int'(C_NOP));
      rst_n = 1'b1;
      n = 0;
      forever begin
        @(negedge clk);
        if (code == C_NOP && cke && !ready) n++;
        else break;
      end
      chk(n >= PWR_CYC && n <= PWR_CYC + 3, "R1 power-up hold", n, PWR_CYC);
      chk(code == C_PRE, "R2 first cmd precharge", int'(code), int'(C_PRE));
      chk(addr[10] == 1'b1, "R8 precharge all", int'(addr[10]), 1);
      tp = cyc;
      wait_cmd(t);
      chk(code == C_REF && t == tp + T_RP, "R2 first refresh", t - tp, T_RP);
      prev = t;
      for (int q = 1; q < INIT_REF; q++) begin
        wait_cmd(t);
        chk(code == C_REF && t == prev + T_RFC, "R2 init refresh gap", t - prev, T_RFC);
        prev = t;
      end
      wait_cmd(t);
      chk(code == C_MRS && t == prev + T_RFC, "R2 mode write", t - prev, T_RFC);
      chk(addr == mode && ba == 2'b00, "R3 mode word", int'(addr), int'(mode));
      chk(!ready, "R4 not ready in init", int'(ready), 0);
      tm = t;
      wait_cmd(t);
      chk(code == C_MRS && t == tm + T_MRD, "R2 ext write gap", t - tm, T_MRD);
      chk(addr == ext && ba == 2'b10, "R3 ext word", int'(addr), int'(ext));
      te = t;
      do @(negedge clk); while (!ready && cyc < te + 50);
      chk(cyc == te + T_MRD, "R4 ready rise", cyc - te, T_MRD);
      last_ar = prev;
    end

    // grant sweep across the slack window and past it
    for (int k = 0; k <= SLACK + 1; k++) begin
      do @(negedge clk); while (!rf_req);
      r = cyc;
      chk(r == last_ar + REF_INT, "R5 request timing", r - last_ar, REF_INT);
      j = 0;
      forever begin
        if (j == k) gnt = 1'b1;
        @(negedge clk);
        if (code != C_NOP) break;
        j++;
      end
      ex = (k < SLACK) ? r + k + 1 : r + SLACK;
      chk(code == C_PRE && cyc == ex, (k < SLACK) ? "R6 granted start" : "R7 forced start", cyc - r, ex - r);
      gnt = 1'b0;
      chk(!ready && addr[10], "R4 ready low on precharge", int'(ready), 0);
      tp = cyc;
      wait_cmd(t);
      chk(code == C_REF && t == tp + T_RP, "R8 refresh after precharge", t - tp, T_RP);
      ta = t;
      do @(negedge clk); while (!ready);
      chk(cyc == ta + T_RFC, "R8 ready return", cyc - ta, T_RFC);
      last_ar = ta;
      if (k == 0) begin
        gnt = 1'b1;
        for (int g = 0; g < 8; g++) begin
          @(negedge clk);
          chk(code == C_NOP && ready && !rf_req, "R6 stray grant ignored", int'(code), int'(C_NOP));
        end
        gnt = 1'b0;
      end
    end

    // self refresh requested in the cycle a refresh is granted
    do @(negedge clk); while (!rf_req);
    r = cyc;
    chk(r == last_ar + REF_INT, "R5 request before self refresh", r - last_ar, REF_INT);
    sr_req = 1'b1;
    gnt = 1'b1;
    @(negedge clk);
    chk(code == C_PRE && cyc == r + 1, "R11 precharge starts self refresh", cyc - r, 1);
    chk(!rf_req && !ready, "R11 request withdrawn", int'(rf_req), 0);
    gnt = 1'b0;
    tp = cyc; prev = tp;
    for (int b = 0; b < SR_BURST; b++) begin
      wait_cmd(t);
      ex = (b == 0) ? tp + T_RP : prev + T_RFC;
      chk(code == C_REF && cke && !ready && t == ex, "R9 entry burst", t - prev, ex - prev);
      prev = t;
    end
    wait_cmd(t);
    chk(code == C_REF && !cke && t == prev + T_RFC, "R9 entry command", t - prev, T_RFC);
    for (int s = 0; s < 20; s++) begin
      @(negedge clk);
      chk(!cke && code == C_NOP && !ready && !rf_req, "R9 hold in self refresh", int'(cke), 0);
    end
    sr_req = 1'b0;
    h = cyc;
    @(negedge clk);
    chk(cke && code == C_NOP && cyc == h + 1, "R10 cke rises with nop", int'(cke), 1);
    hx = cyc;
    wait_cmd(t);
    chk(code == C_REF && t == hx + T_RFC, "R10 nops before first refresh", t - hx, T_RFC);
    prev = t;
    for (int b = 1; b < SR_BURST; b++) begin
      wait_cmd(t);
      chk(code == C_REF && cke && !ready && t == prev + T_RFC, "R10 exit burst", t - prev, T_RFC);
      prev = t;
    end
    do @(negedge clk); while (!ready);
    chk(cyc == prev + T_RFC, "R10 ready after exit", cyc - prev, T_RFC);
    do @(negedge clk); while (!rf_req);
    chk(cyc == prev + REF_INT, "R5 request after exit", cyc - prev, REF_INT);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule